// File: doc/BRIEF.md
# Supply Rail Sequencer and Fault Supervisor

This block sequences a positive boost rail, a negative inverting rail and an independent auxiliary boost rail. It also watches them for faults. The analog side reaches it only as flags: one undervoltage-ok flag, one overtemperature flag, and the comparator results for each rail. From these it drives each rail's enable and discharge control, a reduced switch-current-limit request for the positive rail, and a latched fault indication with a cause code.

A free-running one-millisecond tick sets all time windows. When the main control input goes high, the positive rail starts at once with the reduced current limit. The negative rail follows a set number of ticks later. Deadline checks apply while the rails start. Once the start window passes, debounced level checks take over. Any fault shuts all outputs and holds that state. The fault clears only when the supply drops into lockout or when the main control goes low.

Top module: `rail_seq_supervisor`

## Requirements
- R1: `auxEnable` is high exactly when `auxEn` and `uvloOk` are high and no fault is latched, whatever the state of the main rails.
- R2: A high `mainEn` with `uvloOk` high and `overTemp` low raises `posEnable` on the next clock. `negEnable` rises on the clock of the NEG_DELAY_MS-th tick counted from that start.
- R3: `softLimit` is high from the start until the first clock after `posInReg` is seen high, and is low at every other time.
- R4: If `posInReg` is low at the POS_DL_MS-th start tick, the block faults with `faultCode` 1.
- R5: If `negAboveStart` is high at the NEG_HIGH_DL_MS-th start tick, the block faults with `faultCode` 2.
- R6: At the NEG_REG_DL_MS-th start tick, a low `negInReg` gives a fault with `faultCode` 3. Otherwise the run phase begins and the start-only checks stop.
- R7: In the run phase, `posLow` held high through more than RUN_DEB_MS consecutive ticks gives a fault with `faultCode` 4. The count restarts whenever `posLow` drops.
- R8: In the run phase, `negHigh` held high through more than RUN_DEB_MS consecutive ticks gives a fault with `faultCode` 5. The count restarts whenever `negHigh` drops.
- R9: `overTemp` during start or run gives a fault with `faultCode` 6. While `overTemp` is high, no start begins.
- R10: A latched fault drives `faultLatched` high and every enable low, and it holds while `mainEn` and `uvloOk` stay high. Either one going low clears the fault and sets `faultCode` to 0 on the next clock. A later `mainEn` high restarts the sequence.
- R11: Each discharge output is the inverse of its rail's enable. After reset, all enables are low, all discharges are high and `faultCode` is 0.
- R12: If two checks fire on the same tick, the lower `faultCode` wins. Overtemperature (6) overrides all the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| mainEn | input | 1 | Main control: starts and stops the positive/negative pair |
| auxEn | input | 1 | Auxiliary rail enable request |
| uvloOk | input | 1 | Supply above lockout (low = lockout) |
| overTemp | input | 1 | Junction overtemperature flag |
| posInReg | input | 1 | Positive rail in regulation |
| posLow | input | 1 | Positive rail below its run-time floor |
| negAboveStart | input | 1 | Negative rail above its start-up threshold |
| negInReg | input | 1 | Negative rail in regulation |
| negHigh | input | 1 | Negative rail at least the margin above its nominal |
| posEnable | output | 1 | Positive rail enable |
| negEnable | output | 1 | Negative rail enable |
| auxEnable | output | 1 | Auxiliary rail enable |
| softLimit | output | 1 | Reduced switch current limit for the positive rail |
| posDischarge | output | 1 | Positive rail discharge |
| negDischarge | output | 1 | Negative rail discharge |
| auxDischarge | output | 1 | Auxiliary rail discharge |
| faultLatched | output | 1 | Latched shutdown |
| faultCode | output | 3 | Cause: 0 none, 1 pos start, 2 neg high at start, 3 neg start regulation, 4 pos run, 5 neg run, 6 thermal |

## Verification
The bench builds the block with its default values: a 10-tick negative delay and positive deadline, a 10-tick negative-high deadline, a 20-tick regulation deadline and a 3-tick run debounce. The bench drives the tick itself, so a full start and each debounce window take only a few dozen tick pulses. The positive deadline and the negative-high deadline fall on the same tick, which lets the bench check the priority rule directly. A three-tick debounce is short enough to interrupt part-way, which shows that the run counter restarts.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } seqState_t;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_POS_START = 3'd1,
    FC_NEG_HIGH  = 3'd2,
    FC_NEG_REG   = 3'd3,
    FC_POS_RUN   = 3'd4,
    FC_NEG_RUN   = 3'd5,
    FC_THERMAL   = 3'd6
  } faultCode_t;

  // control -> datapath
  typedef struct packed {
    logic inStart;
    logic inRun;
    logic clear;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic negGo;
    logic posDl;
    logic negHighDl;
    logic negRegDl;
    logic posTrip;
    logic negTrip;
    logic posRegSeen;
  } tmrEvent_t;

endpackage

// File: rtl/rail_seq_timers.sv
module rail_seq_timers
  import rail_seq_pkg::*;
#(
  parameter int NEG_DELAY_MS    = 10,
  parameter int POS_DL_MS       = 10,
  parameter int NEG_HIGH_DL_MS  = 10,
  parameter int NEG_REG_DL_MS   = 20,
  parameter int RUN_DEB_MS      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  ctlStrobe_t ctl,
  input  logic       posInReg,
  input  logic       posLow,
  input  logic       negHigh,
  output tmrEvent_t  evt
);

  localparam int SW = $clog2(NEG_REG_DL_MS + 1);
  localparam int DW = $clog2(RUN_DEB_MS + 1);
  localparam logic [SW-1:0] NEG_GO_AT   = SW'(NEG_DELAY_MS);
  localparam logic [SW-1:0] POS_AT      = SW'(POS_DL_MS - 1);
  localparam logic [SW-1:0] NEG_HIGH_AT = SW'(NEG_HIGH_DL_MS - 1);
  localparam logic [SW-1:0] NEG_REG_AT  = SW'(NEG_REG_DL_MS - 1);
  localparam logic [SW-1:0] START_MAX   = SW'(NEG_REG_DL_MS);
  localparam logic [DW-1:0] DEB_MAX     = DW'(RUN_DEB_MS);

  logic [SW-1:0] startMs;
  logic          regSeenQ;
  logic [DW-1:0] debCnt [2];
  logic [1:0]    debCond;
  logic [1:0]    debTrip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startMs  <= '0;
      regSeenQ <= 1'b0;
    end else if (ctl.clear) begin
      startMs  <= '0;
      regSeenQ <= 1'b0;
    end else begin
      if (ctl.inStart && msTick && startMs != START_MAX)
        startMs <= startMs + 1'b1;
      if (ctl.inStart && posInReg)
        regSeenQ <= 1'b1;
    end
  end

  assign debCond = {negHigh, posLow};

  for (genvar g = 0; g < 2; g++) begin : g_deb
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        debCnt[g] <= '0;
      else if (!ctl.inRun || !debCond[g])
        debCnt[g] <= '0;
      else if (msTick && debCnt[g] != DEB_MAX)
        debCnt[g] <= debCnt[g] + 1'b1;
    end
    assign debTrip[g] = ctl.inRun && debCond[g] && msTick && (debCnt[g] == DEB_MAX);
  end

  always_comb begin
    evt            = '0;
    evt.negGo      = (startMs >= NEG_GO_AT);
    evt.posDl      = ctl.inStart && msTick && (startMs == POS_AT);
    evt.negHighDl  = ctl.inStart && msTick && (startMs == NEG_HIGH_AT);
    evt.negRegDl   = ctl.inStart && msTick && (startMs == NEG_REG_AT);
    evt.posTrip    = debTrip[0];
    evt.negTrip    = debTrip[1];
    evt.posRegSeen = regSeenQ;
  end

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mainEn,
  input  logic       auxEn,
  input  logic       uvloOk,
  input  logic       overTemp,
  input  logic       posInReg,
  input  logic       negAboveStart,
  input  logic       negInReg,
  input  tmrEvent_t  evt,
  output ctlStrobe_t ctl,
  output logic       posEnable,
  output logic       negEnable,
  output logic       auxEnable,
  output logic       softLimit,
  output logic       faultLatched,
  output logic [2:0] faultCode
);

  seqState_t  stateQ, stateD;
  faultCode_t codeQ, codeD;
  logic       stopReq;

  assign stopReq = !uvloOk || !mainEn;

  always_comb begin
    stateD = stateQ;
    codeD  = codeQ;
    unique case (stateQ)
      ST_OFF: begin
        codeD = FC_NONE;
        if (uvloOk && mainEn && !overTemp) stateD = ST_START;
      end
      ST_START: begin
        if (stopReq) stateD = ST_OFF;
        else if (overTemp) begin
          stateD = ST_FAULT; codeD = FC_THERMAL;
        end else if (evt.posDl && !posInReg) begin
          stateD = ST_FAULT; codeD = FC_POS_START;
        end else if (evt.negHighDl && negAboveStart) begin
          stateD = ST_FAULT; codeD = FC_NEG_HIGH;
        end else if (evt.negRegDl) begin
          if (negInReg) stateD = ST_RUN;
          else begin
            stateD = ST_FAULT; codeD = FC_NEG_REG;
          end
        end
      end
      ST_RUN: begin
        if (stopReq) stateD = ST_OFF;
        else if (overTemp) begin
          stateD = ST_FAULT; codeD = FC_THERMAL;
        end else if (evt.posTrip) begin
          stateD = ST_FAULT; codeD = FC_POS_RUN;
        end else if (evt.negTrip) begin
          stateD = ST_FAULT; codeD = FC_NEG_RUN;
        end
      end
      ST_FAULT: begin
        if (stopReq) begin
          stateD = ST_OFF; codeD = FC_NONE;
        end
      end
      default: begin
        stateD = ST_OFF; codeD = FC_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      codeQ  <= FC_NONE;
    end else begin
      stateQ <= stateD;
      codeQ  <= codeD;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.inStart = (stateQ == ST_START);
    ctl.inRun   = (stateQ == ST_RUN);
    ctl.clear   = (stateQ == ST_OFF) || (stateQ == ST_FAULT);
  end

  assign posEnable    = (stateQ == ST_START) || (stateQ == ST_RUN);
  assign negEnable    = (stateQ == ST_RUN) || ((stateQ == ST_START) && evt.negGo);
  assign softLimit    = (stateQ == ST_START) && !evt.posRegSeen;
  assign faultLatched = (stateQ == ST_FAULT);
  assign auxEnable    = auxEn && uvloOk && (stateQ != ST_FAULT);
  assign faultCode    = codeQ;

endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor
  import rail_seq_pkg::*;
#(
  parameter int NEG_DELAY_MS   = 10,
  parameter int POS_DL_MS      = 10,
  parameter int NEG_HIGH_DL_MS = 10,
  parameter int NEG_REG_DL_MS  = 20,
  parameter int RUN_DEB_MS     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       mainEn,
  input  logic       auxEn,
  input  logic       uvloOk,
  input  logic       overTemp,
  input  logic       posInReg,
  input  logic       posLow,
  input  logic       negAboveStart,
  input  logic       negInReg,
  input  logic       negHigh,
  output logic       posEnable,
  output logic       negEnable,
  output logic       auxEnable,
  output logic       softLimit,
  output logic       posDischarge,
  output logic       negDischarge,
  output logic       auxDischarge,
  output logic       faultLatched,
  output logic [2:0] faultCode
);

  ctlStrobe_t ctl;
  tmrEvent_t  evt;

  rail_seq_timers #(
    .NEG_DELAY_MS  (NEG_DELAY_MS),
    .POS_DL_MS     (POS_DL_MS),
    .NEG_HIGH_DL_MS(NEG_HIGH_DL_MS),
    .NEG_REG_DL_MS (NEG_REG_DL_MS),
    .RUN_DEB_MS    (RUN_DEB_MS)
  ) timers_i (
    .clk     (clk),
    .rstN    (rstN),
    .msTick  (msTick),
    .ctl     (ctl),
    .posInReg(posInReg),
    .posLow  (posLow),
    .negHigh (negHigh),
    .evt     (evt)
  );

  rail_seq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .mainEn       (mainEn),
    .auxEn        (auxEn),
    .uvloOk       (uvloOk),
    .overTemp     (overTemp),
    .posInReg     (posInReg),
    .negAboveStart(negAboveStart),
    .negInReg     (negInReg),
    .evt          (evt),
    .ctl          (ctl),
    .posEnable    (posEnable),
    .negEnable    (negEnable),
    .auxEnable    (auxEnable),
    .softLimit    (softLimit),
    .faultLatched (faultLatched),
    .faultCode    (faultCode)
  );

  assign posDischarge = !posEnable;
  assign negDischarge = !negEnable;
  assign auxDischarge = !auxEnable;

endmodule

// File: rtl/rail_seq_checker.sv
module rail_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       mainEn,
  input logic       uvloOk,
  input logic       posEnable,
  input logic       negEnable,
  input logic       auxEnable,
  input logic       softLimit,
  input logic       posDischarge,
  input logic       negDischarge,
  input logic       faultLatched,
  input logic [2:0] faultCode
);

  AST_NEG_NEEDS_POS: assert property (@(posedge clk) disable iff (!rstN)
    negEnable |-> posEnable); // R2

  AST_POS_RISE_FROM_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(posEnable) |-> $past(mainEn)); // R2

  AST_SOFT_LIMIT_ON_POS: assert property (@(posedge clk) disable iff (!rstN)
    softLimit |-> posEnable); // R3

  AST_FAULT_RAILS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!posEnable && !negEnable && !auxEnable)); // R10

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && mainEn && uvloOk) |=> faultLatched); // R10

  AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !uvloOk |=> (!faultLatched && faultCode == 3'd0)); // R10

  AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (faultCode != 3'd0)); // R12

  AST_DISCHARGE_POS: assert property (@(posedge clk) disable iff (!rstN)
    posDischarge != posEnable); // R11

  AST_DISCHARGE_NEG: assert property (@(posedge clk) disable iff (!rstN)
    negDischarge != negEnable); // R11

endmodule

bind rail_seq_supervisor rail_seq_checker chk_i (.*);

// File: tb/rail_seq_supervisor_tb_top.sv
module rail_seq_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0, mainEn = 1'b0, auxEn = 1'b0, uvloOk = 1'b0, overTemp = 1'b0;
  logic       posInReg = 1'b0, posLow = 1'b0, negAboveStart = 1'b0, negInReg = 1'b0, negHigh = 1'b0;
  logic       posEnable, negEnable, auxEnable, softLimit;
  logic       posDischarge, negDischarge, auxDischarge, faultLatched;
  logic [2:0] faultCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rail_seq_supervisor dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; msTick = 0; mainEn = 0; auxEn = 0; uvloOk = 0; overTemp = 0;
    posInReg = 0; posLow = 0; negAboveStart = 0; negInReg = 0; negHigh = 0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    uvloOk = 1'b1;
  endtask

  task automatic startToRun();
    posInReg = 1; negInReg = 1; negAboveStart = 0;
    mainEn = 1;
    idle(1);
    tick(20);
  endtask

  task automatic testResetState();
    doReset();
    chk("R11", "posEnable", posEnable, 0);
    chk("R11", "negEnable", negEnable, 0);
    chk("R11", "posDischarge", posDischarge, 1);
    chk("R11", "negDischarge", negDischarge, 1);
    chk("R11", "auxDischarge", auxDischarge, 1);
    chk("R11", "faultCode", faultCode, 0);
  endtask

  task automatic testAux();
    doReset();
    auxEn = 1; idle(1);
    chk("R1", "auxEnable on", auxEnable, 1);
    chk("R1", "posEnable off", posEnable, 0);
    auxEn = 0; idle(1);
    chk("R1", "auxEnable off", auxEnable, 0);
    chk("R11", "auxDischarge", auxDischarge, 1);
  endtask

  task automatic testNormalStart();
    doReset();
    auxEn = 1;
    mainEn = 1; idle(1);
    chk("R2", "posEnable at start", posEnable, 1);
    chk("R3", "softLimit at start", softLimit, 1);
    chk("R2", "negEnable at start", negEnable, 0);
    tick(2);
    posInReg = 1; idle(1);
    chk("R3", "softLimit released", softLimit, 0);
    tick(7);
    chk("R2", "negEnable before delay", negEnable, 0);
    chk("R11", "negDischarge before delay", negDischarge, 1);
    tick(1);
    chk("R2", "negEnable after delay", negEnable, 1);
    chk("R4", "no fault at pos deadline", faultLatched, 0);
    negInReg = 1;
    tick(10);
    chk("R6", "no fault entering run", faultLatched, 0);
    chk("R1", "aux independent", auxEnable, 1);
    posLow = 1; tick(3);
    chk("R7", "no trip at debounce", faultLatched, 0);
    tick(1);
    chk("R7", "pos run trip", faultLatched, 1);
    chk("R7", "pos run code", faultCode, 4);
    chk("R10", "rails off in fault", posEnable + negEnable, 0);
    chk("R1", "aux off in fault", auxEnable, 0);
    idle(5);
    chk("R10", "fault holds", faultLatched, 1);
    mainEn = 0; idle(1);
    chk("R10", "cleared by mainEn low", faultLatched, 0);
    chk("R10", "code cleared", faultCode, 0);
    mainEn = 1; idle(1);
    chk("R10", "restart", posEnable, 1);
  endtask

  task automatic testPosDebounceRestart();
    doReset();
    startToRun();
    posLow = 1; tick(3);
    posLow = 0; idle(1);
    posLow = 1; tick(3);
    chk("R7", "counter restarted", faultLatched, 0);
    tick(1);
    chk("R7", "trip after restart", faultCode, 4);
  endtask

  task automatic testStartInRunIgnoresPosLow();
    doReset();
    posInReg = 1; posLow = 1; mainEn = 1; idle(1);
    tick(5);
    chk("R7", "posLow ignored during start", faultLatched, 0);
  endtask

  task automatic testNegRun();
    doReset();
    startToRun();
    negHigh = 1; tick(3);
    chk("R8", "no neg trip at debounce", faultLatched, 0);
    tick(1);
    chk("R8", "neg run code", faultCode, 5);
  endtask

  task automatic testPosStart();
    doReset();
    mainEn = 1; idle(1);
    tick(9);
    chk("R4", "no fault before deadline", faultLatched, 0);
    tick(1);
    chk("R4", "pos start code", faultCode, 1);
    chk("R10", "posEnable off", posEnable, 0);
  endtask

  task automatic testNegHigh();
    doReset();
    posInReg = 1; negAboveStart = 1; mainEn = 1; idle(1);
    tick(10);
    chk("R5", "neg high code", faultCode, 2);
  endtask

  task automatic testPriority();
    doReset();
    negAboveStart = 1; mainEn = 1; idle(1);
    tick(10);
    chk("R12", "pos start wins", faultCode, 1);
  endtask

  task automatic testNegReg();
    doReset();
    posInReg = 1; mainEn = 1; idle(1);
    tick(19);
    chk("R6", "no fault before reg deadline", faultLatched, 0);
    tick(1);
    chk("R6", "neg reg code", faultCode, 3);
  endtask

  task automatic testThermal();
    doReset();
    startToRun();
    overTemp = 1; idle(1);
    chk("R9", "thermal code", faultCode, 6);
    uvloOk = 0; idle(1);
    chk("R10", "cleared by lockout", faultLatched, 0);
    uvloOk = 1; idle(2);
    chk("R9", "start blocked by overtemp", posEnable, 0);
    overTemp = 0; idle(1);
    chk("R9", "start after cool", posEnable, 1);
    overTemp = 1; posLow = 1; tick(1);
    chk("R12", "thermal overrides", faultCode, 6);
  endtask

  initial begin
    testResetState();
    testAux();
    testNormalStart();
    testPosDebounceRestart();
    testStartInRunIgnoresPosLow();
    testNegRun();
    testPosStart();
    testNegHigh();
    testPriority();
    testNegReg();
    testThermal();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule